// File: doc/BRIEF.md
# Row-Wide Store/Recall Copy Engine

This block moves the whole contents of a working RAM into a nonvolatile shadow array (store), or moves the shadow contents back into the RAM (recall). Both arrays have 128 rows of 64 bytes, which is 8192 bytes each. Each array is reached through a synchronous memory port one row (512 bits) wide. A controller gives a one-cycle start pulse together with the operation type. The engine then walks the rows in ascending order. For each row it runs two phases: it wipes the destination row, then it copies the source row into it. When the last row is finished, done pulses.

A store wipes a shadow row to the erased pattern (every byte 0xFF) and then programs the row from the RAM. A recall clears a RAM row to zero and then loads it from the shadow array. A recall never touches the shadow array, so it can be repeated any number of times. A programmable wait count stands in for slow nonvolatile writes: it stretches each phase. A store is cut short at once if the supply-good input drops.

Top module: `nv_copy_engine`

## Requirements
- R1: Out of reset, busy_o and done_o are low and no memory write is issued.
- R2: op_recall_i = 0 selects store. When a store completes, every shadow row equals the corresponding RAM row, and the RAM is not written.
- R3: During a store, each shadow row is first written with all bytes 0xFF. It is then written with the RAM row.
- R4: op_recall_i = 1 selects recall. During a recall, each RAM row is first written with zero and then with the shadow row. On completion the RAM equals the shadow array.
- R5: A recall never writes the shadow array. Recalls can be repeated with the same result.
- R6: Rows are processed from 0 up to 127 in ascending order. done_o is a single-cycle pulse in the first cycle after busy_o falls.
- R7: wait_cycles_i (W) is sampled when start is accepted. Each row then takes 3+2W cycles, so busy_o stays high for 128·(3+2W) cycles. Read data returns on *_rdata_i one cycle after a read request.
- R8: A start pulse while busy_o is high is ignored. The running operation keeps its type, its wait count and its length.
- R9: If supply_ok_i is low during a store, no write is issued in that cycle. busy_o is low in the next cycle, done_o does not pulse, and rows not yet finished are left as they are.
- R10: A store start while supply_ok_i is low is ignored. A recall starts and runs to completion whatever the state of supply_ok_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| op_recall_i | input | 1 | 1 = recall, 0 = store |
| wait_cycles_i | input | 8 | Extra cycles per phase |
| supply_ok_i | input | 1 | Supply good; low aborts or inhibits a store |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ram_en_o | output | 1 | RAM port enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 7 | RAM row address |
| ram_wdata_o | output | 512 | RAM write row |
| ram_rdata_i | input | 512 | RAM read row (one-cycle latency) |
| shd_en_o | output | 1 | Shadow port enable |
| shd_we_o | output | 1 | Shadow write enable |
| shd_addr_o | output | 7 | Shadow row address |
| shd_wdata_o | output | 512 | Shadow write row |
| shd_rdata_i | input | 512 | Shadow read row (one-cycle latency) |

## Verification
Some rules are checked by the assertions on every cycle:
- a recall never writes the shadow array;
- the row counter steps by one;
- done lasts a single cycle and follows the last row;
- a low supply ends a store on the next edge;
- a store start is refused while the supply is low;
- a start during busy leaves the operation type unchanged.

Other properties can only be shown by the bench's scenarios, using its own memory models:
- the wipe-then-copy order within each row, and the data written;
- the final contents of both arrays;
- the exact cycle count for each wait value;
- which rows survive a store that is aborted part-way.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIPE,
    ST_WAIT_W,
    ST_FETCH,
    ST_COPY,
    ST_WAIT_C
  } nvc_state_e;
endpackage

// File: rtl/nvc_row_ctr.sv
module nvc_row_ctr #(
  parameter int ROWS = 128,
  localparam int AW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] row_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (clr_i) row_o <= '0;
    else if (inc_i) row_o <= row_o + 1'b1;
  end

  assign last_o = (row_o == AW'(ROWS - 1));

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (row_o == AW'($past(row_o) + 1'b1))); // R6
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o); // R6
endmodule

// File: rtl/nvc_wait_tmr.sv
module nvc_wait_tmr #(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= WAIT_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0)); // R7
endmodule

// File: rtl/nvc_seq.sv
module nvc_seq
  import nvc_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_recall_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic              supply_ok_i,
  input  logic              row_last_i,
  input  logic              tmr_last_i,
  output nvc_state_e        state_o,
  output logic              op_recall_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic              row_clr_o,
  output logic              row_inc_o,
  output logic              tmr_load_o,
  output logic              tmr_dec_o,
  output logic              busy_o,
  output logic              done_o
);
  nvc_state_e state_q, state_d;
  logic op_q;
  logic [WAIT_W-1:0] wait_q;
  logic accept, abort, row_end, no_wait;

  assign no_wait = (wait_q == '0);
  assign accept  = (state_q == ST_IDLE) && start_i && (op_recall_i || supply_ok_i);
  assign abort   = (state_q != ST_IDLE) && !op_q && !supply_ok_i;
  assign row_end = ((state_q == ST_COPY) && no_wait) ||
                   ((state_q == ST_WAIT_C) && tmr_last_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_WIPE;
      ST_WIPE:   state_d = no_wait ? ST_FETCH : ST_WAIT_W;
      ST_WAIT_W: if (tmr_last_i) state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_COPY;
      ST_COPY:   if (no_wait) state_d = row_last_i ? ST_IDLE : ST_WIPE;
                 else state_d = ST_WAIT_C;
      ST_WAIT_C: if (tmr_last_i) state_d = row_last_i ? ST_IDLE : ST_WIPE;
      default:   state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      wait_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= row_end && row_last_i && !abort;
      if (accept) begin
        op_q   <= op_recall_i;
        wait_q <= wait_cycles_i;
      end
    end
  end

  assign state_o     = state_q;
  assign op_recall_o = op_q;
  assign wait_o      = wait_q;
  assign row_clr_o   = accept;
  assign row_inc_o   = row_end && !row_last_i && !abort;
  assign tmr_load_o  = (state_q == ST_WIPE) || (state_q == ST_COPY);
  assign tmr_dec_o   = (state_q == ST_WAIT_W) || (state_q == ST_WAIT_C);
  assign busy_o      = (state_q != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && $past(row_last_i))); // R6
  AST_ABORT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !op_q && !supply_ok_i) |=> (!busy_o && !done_o)); // R9
  AST_STORE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !op_recall_i && !supply_ok_i) |=> !busy_o); // R10
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(wait_q))); // R8
endmodule

// File: rtl/nv_copy_engine.sv
module nv_copy_engine
  import nvc_pkg::*;
#(
  parameter int         ROWS       = 128,
  parameter int         ROW_BYTES  = 64,
  parameter int         WAIT_W     = 8,
  parameter logic [7:0] ERASE_BYTE = 8'hFF,
  localparam int        AW         = $clog2(ROWS),
  localparam int        ROW_W      = ROW_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_recall_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic              supply_ok_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [ROW_W-1:0]  ram_wdata_o,
  input  logic [ROW_W-1:0]  ram_rdata_i,
  output logic              shd_en_o,
  output logic              shd_we_o,
  output logic [AW-1:0]     shd_addr_o,
  output logic [ROW_W-1:0]  shd_wdata_o,
  input  logic [ROW_W-1:0]  shd_rdata_i
);
  nvc_state_e        state;
  logic              op_recall, row_clr, row_inc, row_last;
  logic              tmr_load, tmr_dec, tmr_last;
  logic [WAIT_W-1:0] wait_val;
  logic [AW-1:0]     row;
  logic [ROW_W-1:0]  erase_row, clear_row;
  logic              wipe, fetch, copy, phase_wr;

  nvc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .op_recall_i, .wait_cycles_i, .supply_ok_i,
    .row_last_i (row_last),
    .tmr_last_i (tmr_last),
    .state_o    (state),
    .op_recall_o(op_recall),
    .wait_o     (wait_val),
    .row_clr_o  (row_clr),
    .row_inc_o  (row_inc),
    .tmr_load_o (tmr_load),
    .tmr_dec_o  (tmr_dec),
    .busy_o,
    .done_o
  );

  nvc_row_ctr #(.ROWS(ROWS)) u_row (
    .clk_i, .rst_ni,
    .clr_i (row_clr),
    .inc_i (row_inc),
    .row_o (row),
    .last_o(row_last)
  );

  nvc_wait_tmr #(.WAIT_W(WAIT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i    (tmr_load),
    .load_val_i(wait_val),
    .dec_i     (tmr_dec),
    .last_o    (tmr_last)
  );

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_pat
    assign erase_row[b*8 +: 8] = ERASE_BYTE;
    assign clear_row[b*8 +: 8] = 8'h00;
  end

  assign wipe     = (state == ST_WIPE);
  assign fetch    = (state == ST_FETCH);
  assign copy     = (state == ST_COPY);
  assign phase_wr = wipe || copy;

  // store writes are suppressed in the very cycle the supply drops
  assign shd_we_o    = !op_recall && phase_wr && supply_ok_i;
  assign ram_we_o    = op_recall && phase_wr;
  assign ram_en_o    = ram_we_o || (fetch && !op_recall);
  assign shd_en_o    = shd_we_o || (fetch && op_recall);
  assign ram_addr_o  = row;
  assign shd_addr_o  = row;
  assign ram_wdata_o = wipe ? clear_row : shd_rdata_i;
  assign shd_wdata_o = wipe ? erase_row : ram_rdata_i;

  AST_RECALL_SHD_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_recall) |-> !shd_we_o); // R5
  AST_ONE_ARRAY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && shd_we_o)); // R2
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(ram_we_o || shd_we_o)); // R1
endmodule

// File: tb/nv_copy_engine_tb.sv
module nv_copy_engine_tb;
  localparam int ROWS = 128;
  localparam int ROW_W = 512;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, op_recall_i = 1'b0, supply_ok_i = 1'b1;
  logic [7:0] wait_cycles_i = '0;
  logic busy_o, done_o;
  logic ram_en_o, ram_we_o, shd_en_o, shd_we_o;
  logic [6:0] ram_addr_o, shd_addr_o;
  logic [ROW_W-1:0] ram_wdata_o, shd_wdata_o, ram_rdata_i, shd_rdata_i;

  always #2 clk = ~clk;

  nv_copy_engine u_dut (
    .clk_i(clk), .rst_ni, .start_i, .op_recall_i, .wait_cycles_i, .supply_ok_i,
    .busy_o, .done_o,
    .ram_en_o, .ram_we_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i,
    .shd_en_o, .shd_we_o, .shd_addr_o, .shd_wdata_o, .shd_rdata_i
  );

  logic [ROW_W-1:0] ram_m [ROWS];
  logic [ROW_W-1:0] shd_m [ROWS];
  logic [ROW_W-1:0] ram_ini [ROWS];
  logic [ROW_W-1:0] shd_ini [ROWS];
  logic load_req = 1'b0, mon_clr = 1'b0;
  int wr_phase [ROWS];
  int rows_ok, mon_err, shd_wr_cnt, ram_wr_cnt, last_addr;
  int n_chk = 0, n_fail = 0, cyc = 0;

  // memory models with one-cycle read latency, plus write monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load_req) begin
      for (int i = 0; i < ROWS; i++) begin
        ram_m[i] <= ram_ini[i];
        shd_m[i] <= shd_ini[i];
      end
    end else begin
      if (ram_en_o && !ram_we_o) ram_rdata_i <= ram_m[ram_addr_o];
      if (shd_en_o && !shd_we_o) shd_rdata_i <= shd_m[shd_addr_o];
      if (ram_en_o && ram_we_o) ram_m[ram_addr_o] <= ram_wdata_o;
      if (shd_en_o && shd_we_o) shd_m[shd_addr_o] <= shd_wdata_o;
    end
    if (mon_clr) begin
      for (int i = 0; i < ROWS; i++) wr_phase[i] <= 0;
      rows_ok <= 0; mon_err <= 0; shd_wr_cnt <= 0; ram_wr_cnt <= 0; last_addr <= 0;
    end else begin
      if (shd_we_o) begin
        shd_wr_cnt <= shd_wr_cnt + 1;
        if (int'(shd_addr_o) < last_addr) mon_err <= mon_err + 1;
        last_addr <= int'(shd_addr_o);
        wr_phase[shd_addr_o] <= wr_phase[shd_addr_o] + 1;
        if (wr_phase[shd_addr_o] == 0 && shd_wdata_o != {ROW_W{1'b1}}) mon_err <= mon_err + 1;
        if (wr_phase[shd_addr_o] == 1) begin
          if (shd_wdata_o == ram_m[shd_addr_o]) rows_ok <= rows_ok + 1;
          else mon_err <= mon_err + 1;
        end
      end
      if (ram_we_o) begin
        ram_wr_cnt <= ram_wr_cnt + 1;
        if (int'(ram_addr_o) < last_addr) mon_err <= mon_err + 1;
        last_addr <= int'(ram_addr_o);
        wr_phase[ram_addr_o] <= wr_phase[ram_addr_o] + 1;
        if (wr_phase[ram_addr_o] == 0 && ram_wdata_o != '0) mon_err <= mon_err + 1;
        if (wr_phase[ram_addr_o] == 1) begin
          if (ram_wdata_o == shd_m[ram_addr_o]) rows_ok <= rows_ok + 1;
          else mon_err <= mon_err + 1;
        end
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [ROW_W-1:0] rnd_row();
    logic [ROW_W-1:0] r;
    for (int w = 0; w < ROW_W / 32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic int exp_busy(input int w);
    return ROWS * (3 + 2 * w);
  endfunction

  task automatic fill_arrays();
    for (int i = 0; i < ROWS; i++) begin
      ram_ini[i] = rnd_row();
      shd_ini[i] = rnd_row();
    end
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
  endtask

  // count rows where ram and shadow differ
  function automatic int diff_rows();
    int n = 0;
    for (int i = 0; i < ROWS; i++) if (ram_m[i] != shd_m[i]) n++;
    return n;
  endfunction

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  // runs one operation; optional disturbing start mid-run
  task automatic run_op(input logic recall, input int w, input string req, input bit poke);
    int busy_n = 0;
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; op_recall_i = recall; wait_cycles_i = 8'(w);
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o && busy_n < 5000) begin
      busy_n++;
      if (poke && busy_n == 50) begin
        start_i = 1'b1; op_recall_i = ~recall; wait_cycles_i = 8'd0;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    check({req, " R7 busy length"}, busy_n, exp_busy(w));
    check({req, " R6 done after busy"}, done_o, 1);
    @(negedge clk);
    check({req, " R6 done single cycle"}, done_o, 0);
    check({req, " R3/R4 two-phase rows ok (R3 R4)"}, rows_ok, ROWS);
    check({req, " R6 ascending order, data"}, mon_err, 0);
    check({req, " R2 final contents equal"}, diff_rows(), 0);
    if (recall) check({req, " R5 no shadow write"}, shd_wr_cnt, 0);
    else        check({req, " R2 no ram write"}, ram_wr_cnt, 0);
  endtask

  initial begin
    int k, nabort, bad, w;
    void'($urandom(32'd20240611));
    fill_arrays();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", busy_o, 0);
    check("R1 done in reset", done_o, 0);
    check("R1 no write in reset", {ram_we_o, shd_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", busy_o, 0);

    // directed: store W=0 then recall W=1 (R2 R3 R4)
    run_op(1'b0, 0, "store w0", 1'b0);
    fill_arrays();
    run_op(1'b1, 1, "recall w1", 1'b0);
    // R5: repeated recall gives same result, shadow unchanged
    run_op(1'b1, 0, "recall again", 1'b0);
    bad = 0;
    for (int i = 0; i < ROWS; i++) if (shd_m[i] != shd_ini[i]) bad++;
    check("R5 shadow untouched by recalls", bad, 0);

    // R8: start during busy ignored
    fill_arrays();
    run_op(1'b1, 2, "R8 recall poked", 1'b1);

    // R9: abort store after row k completes
    fill_arrays();
    clear_mon();
    k = 37; nabort = k * 5 + 1;
    @(negedge clk);
    start_i = 1'b1; op_recall_i = 1'b0; wait_cycles_i = 8'd1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 1; c < nabort; c++) @(negedge clk);
    check("R9 busy before abort", busy_o, 1);
    supply_ok_i = 1'b0;
    @(negedge clk);
    check("R9 busy drops next cycle", busy_o, 0);
    check("R9 no done on abort", done_o, 0);
    repeat (3) @(negedge clk);
    check("R9 still no done", done_o, 0);
    bad = 0;
    for (int i = 0; i < k; i++) if (shd_m[i] != ram_ini[i]) bad++;
    check("R9 finished rows copied", bad, 0);
    bad = 0;
    for (int i = k; i < ROWS; i++) if (shd_m[i] != shd_ini[i]) bad++;
    check("R9 unfinished rows untouched", bad, 0);

    // R10: store start ignored with supply low
    @(negedge clk);
    start_i = 1'b1; op_recall_i = 1'b0; wait_cycles_i = 8'd0;
    @(negedge clk);
    start_i = 1'b0;
    check("R10 store inhibited", busy_o, 0);
    repeat (2) @(negedge clk);
    check("R10 still idle", busy_o, 0);
    // R10: recall runs with supply low
    fill_arrays();
    run_op(1'b1, 0, "R10 recall low supply", 1'b0);
    supply_ok_i = 1'b1;

    // random operations
    for (int n = 0; n < 6; n++) begin
      fill_arrays();
      w = int'($urandom_range(0, 3));
      run_op(logic'($urandom_range(0, 1)), w, "random", 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R7: actual %0d expected below %0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule